// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM Core with Selectable Read Pipelining

This block is a clocked single-port memory whose words are 18 bits wide, split into two 9-bit byte lanes. Its depth is set by an address-width parameter. Every address, data and control input is captured on the rising edge of the clock. A captured cycle is one of three kinds. It is a deselect when the three select inputs do not all agree. It is a write when the whole-word write strobe or the lane write enable is active. Otherwise it is a read.

A single mode input chooses how read data reaches the output. In flow-through mode the data comes from the array as soon as the address has been registered. In pipelined mode an output register adds one clock. Deselects and writes go through the same stages as reads, which is what turns the output drivers off. In pipelined mode the drivers therefore stay on for one extra cycle after the last read. The output enable and the standby input act on the drivers without waiting for a clock. Standby also blocks every access while it is high, and the stored contents are kept.

The access stage is a state machine with the states CYC_IDLE, CYC_READ and CYC_WRITE. Each clock edge loads the kind of the cycle just captured, and standby or a deselect forces CYC_IDLE. The drive stage is a second state machine with the states DRV_OFF and DRV_ON. It enters DRV_ON one edge after a CYC_READ and returns to DRV_OFF one edge after any other kind of cycle or under standby. Reset puts both machines in their idle states: CYC_IDLE and DRV_OFF.

Top module: `sram_core`

## Requirements
- R1: A selected cycle with `wr_all_n`=0 writes both byte lanes with `wdata` at `addr`, whatever `lane_n` holds.
- R2: A selected cycle with `wr_all_n`=1 and `wr_byte_n`=0 writes lane i (bits 9i+8..9i) only where `lane_n[i]`=0. Lanes whose bit is 1 keep their old contents. With `lane_n`=2'b11 nothing is written, and the cycle still counts as a write.
- R3: When `wr_all_n`=0 and `wr_byte_n`=0 are both active, the whole-word strobe takes priority and both lanes are written.
- R4: A cycle is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect, which writes nothing and drives no data.
- R5: With `flow_thru`=1, a read captured at edge N drives `rdata` with the word at its address, and asserts `rdata_drive`, from just after edge N until edge N+1.
- R6: With `flow_thru`=0, a read captured at edge N drives its data from just after edge N+1 until edge N+2. A write to the same address at edge N+1 does not change that data.
- R7: Deselect and write cycles turn the drivers off with the same latency as a read: just after edge N in flow-through mode and just after edge N+1 in pipelined mode. In pipelined mode the drivers therefore stay on for one cycle after the last read.
- R8: While `out_en_n`=1, `rdata_drive` is 0 at once, without waiting for a clock edge.
- R9: While `standby`=1, `rdata_drive` is 0 at once. Accesses captured while it is high are ignored and the memory contents are kept. Normal operation resumes at the first edge after it falls.
- R10: While `rst_n`=0 and after reset, with no read issued, `rdata_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address |
| wdata | input | 18 | Write data, lane 1 in bits 17:9, lane 0 in bits 8:0 |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| wr_all_n | input | 1 | Whole-word write strobe, active low |
| wr_byte_n | input | 1 | Lane write enable, active low |
| lane_n | input | 2 | Per-lane write strobes, active low |
| flow_thru | input | 1 | 1 = flow-through read, 0 = pipelined read |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| standby | input | 1 | Asynchronous standby, active high |
| rdata | output | 18 | Read data; zero while not driven |
| rdata_drive | output | 1 | Output driver enable for `rdata` |

## Verification
A wrong access state shows up as a wrong value of `rdata_drive`. In flow-through mode the error is visible in the very cycle after the capturing edge. In pipelined mode it is visible one cycle later, since the drive stage delays it by one edge. A wrong drive state shows only in pipelined mode: the drivers turn off one cycle early, or stay on one cycle too long after a deselect. Corrupted lane masks or a wrong select decode stay hidden until the affected address is read back. The bench therefore reads back every address it writes.

// File: rtl/sram_pkg.sv
`timescale 1ns/10ps
package sram_pkg;

    // Kind of access captured at a clock edge (access stage)
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // State of the pipelined drive stage
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drv_e;

endpackage

// File: rtl/sram_cmd_decode.sv
`timescale 1ns/10ps
module sram_cmd_decode
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [NBYTES-1:0] lane_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [NBYTES-1:0] wr_mask,
    output cyc_e              cyc_q,
    output logic [ADDR_W-1:0] rd_addr_q
);

    localparam logic [NBYTES-1:0] ALL_LANES = {NBYTES{1'b1}};

    logic selected;
    cyc_e cyc_d;
    logic [NBYTES-1:0] mask_d;

    assign selected = !sel_a_n && sel_b && !sel_c_n;

    // Next-state decode: standby and deselect both map to CYC_IDLE;
    // the whole-word strobe outranks the lane enable.
    always_comb begin
        cyc_d  = CYC_IDLE;
        mask_d = '0;
        if (standby || !selected) begin
            cyc_d = CYC_IDLE;
        end else if (!wr_all_n) begin
            cyc_d  = CYC_WRITE;
            mask_d = ALL_LANES;
        end else if (!wr_byte_n) begin
            cyc_d  = CYC_WRITE;
            mask_d = ~lane_n;
        end else begin
            cyc_d = CYC_READ;
        end
    end

    // Output decode for the array write port
    always_comb begin
        wr_en   = 1'b0;
        wr_mask = '0;
        unique case (cyc_d)
            CYC_WRITE: begin
                wr_en   = 1'b1;
                wr_mask = mask_d;
            end
            CYC_READ,
            CYC_IDLE: begin
                wr_en   = 1'b0;
                wr_mask = '0;
            end
            default: begin
                wr_en   = 1'b0;
                wr_mask = '0;
            end
        endcase
    end

    // Access-stage state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q     <= CYC_IDLE;
            rd_addr_q <= '0;
        end else begin
            cyc_q <= cyc_d;
            if (cyc_d == CYC_READ) begin
                rd_addr_q <= addr;
            end
        end
    end

endmodule

// File: rtl/sram_array.sv
`timescale 1ns/10ps
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [NBYTES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    // One storage column per byte lane; lanes write independently
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) begin
                lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/sram_read_path.sv
`timescale 1ns/10ps
module sram_read_path
    import sram_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              flow_thru,
    input  logic              out_en_n,
    input  cyc_e              cyc_q,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);

    drv_e              drv_q;
    drv_e              drv_d;
    logic [DATA_W-1:0] out_q;
    logic              stage_on;
    logic [DATA_W-1:0] stage_data;

    // Next state of the drive stage: follows the access stage one edge later
    always_comb begin
        drv_d = DRV_OFF;
        if (!standby) begin
            unique case (cyc_q)
                CYC_READ:  drv_d = DRV_ON;
                CYC_WRITE: drv_d = DRV_OFF;
                CYC_IDLE:  drv_d = DRV_OFF;
                default:   drv_d = DRV_OFF;
            endcase
        end
    end

    // Drive-stage state register and output data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= DRV_OFF;
            out_q <= '0;
        end else begin
            drv_q <= drv_d;
            if (drv_d == DRV_ON) begin
                out_q <= arr_data;
            end
        end
    end

    // Output process: mode select, then asynchronous driver gating
    always_comb begin
        unique case (flow_thru)
            1'b1: begin
                stage_on   = (cyc_q == CYC_READ);
                stage_data = arr_data;
            end
            1'b0: begin
                stage_on   = (drv_q == DRV_ON);
                stage_data = out_q;
            end
            default: begin
                stage_on   = 1'b0;
                stage_data = '0;
            end
        endcase
        rdata_drive = stage_on && !out_en_n && !standby;
        rdata       = rdata_drive ? stage_data : '0;
    end

endmodule

// File: rtl/sram_core.sv
`timescale 1ns/10ps
module sram_core
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     sel_a_n,
    input  logic                     sel_b,
    input  logic                     sel_c_n,
    input  logic                     wr_all_n,
    input  logic                     wr_byte_n,
    input  logic [NBYTES-1:0]        lane_n,
    input  logic                     flow_thru,
    input  logic                     out_en_n,
    input  logic                     standby,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rdata_drive
);

    localparam int DATA_W = NBYTES * BYTE_W;

    logic              wr_en;
    logic [NBYTES-1:0] wr_mask;
    cyc_e              cyc_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] arr_data;

    sram_cmd_decode #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_n    (lane_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .cyc_q     (cyc_q),
        .rd_addr_q (rd_addr_q)
    );

    sram_array #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .wr_addr (addr),
        .wr_data (wdata),
        .rd_addr (rd_addr_q),
        .rd_data (arr_data)
    );

    sram_read_path #(
        .DATA_W (DATA_W)
    ) u_rdpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby     (standby),
        .flow_thru   (flow_thru),
        .out_en_n    (out_en_n),
        .cyc_q       (cyc_q),
        .arr_data    (arr_data),
        .rdata       (rdata),
        .rdata_drive (rdata_drive)
    );

endmodule

// File: rtl/sram_core_chk.sv
`timescale 1ns/10ps
module sram_core_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_a_n,
    input logic sel_b,
    input logic sel_c_n,
    input logic wr_all_n,
    input logic wr_byte_n,
    input logic flow_thru,
    input logic out_en_n,
    input logic standby,
    input logic rdata_drive
);

    logic rd_cmd;
    assign rd_cmd = !sel_a_n && sel_b && !sel_c_n && wr_all_n && wr_byte_n && !standby;

    // R5: flow-through read drives in the next cycle
    p_flow_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && rd_cmd) |=> (!flow_thru || out_en_n || standby || rdata_drive));

    // R6: pipelined read drives two edges later
    p_pipe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && rd_cmd) ##1 (!flow_thru && !standby)
        |=> (flow_thru || out_en_n || standby || rdata_drive));

    // R7: flow-through non-read turns drivers off after the next edge
    p_flow_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && !rd_cmd) |=> (!flow_thru || !rdata_drive));

    // R7: pipelined non-read turns drivers off one edge later
    p_pipe_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && !rd_cmd) ##1 !flow_thru |=> (flow_thru || !rdata_drive));

    // R8: output enable gates the drivers
    p_oe_gate_r8: assert property (@(negedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_drive);

    // R9: standby gates the drivers
    p_standby_gate_r9: assert property (@(negedge clk) disable iff (!rst_n)
        standby |-> !rdata_drive);

    // R10: no drive while reset is held
    p_reset_quiet_r10: assert property (@(negedge clk)
        !rst_n |-> !rdata_drive);

endmodule

bind sram_core sram_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .wr_all_n    (wr_all_n),
    .wr_byte_n   (wr_byte_n),
    .flow_thru   (flow_thru),
    .out_en_n    (out_en_n),
    .standby     (standby),
    .rdata_drive (rdata_drive)
);

// File: tb/test_sram_core.sv
`timescale 1ns/10ps
module test_sram_core;

    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b1;
    logic          sel_c_n = 1'b0;
    logic          wr_all_n = 1'b1;
    logic          wr_byte_n = 1'b1;
    logic [1:0]    lane_n = 2'b11;
    logic          flow_thru = 1'b1;
    logic          out_en_n = 1'b0;
    logic          standby = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    sram_core #(.ADDR_W(AW)) i_sram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .flow_thru(flow_thru), .out_en_n(out_en_n), .standby(standby),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    typedef struct {
        int            due;
        bit            exp_on;
        logic [DW-1:0] exp_d;
        string         tag;
    } item_t;

    item_t         sbq[$];
    logic [DW-1:0] model [1<<AW];
    int            cyc = 0;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [DW:0] act, input logic [DW:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: applies one command at the falling edge and pushes its expectation
    task automatic cmd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic s1n, input logic s2, input logic s3n,
                       input logic wan, input logic wbn, input logic [1:0] ln,
                       input logic slp, input string tag);
        item_t it;
        bit    sel;
        @(negedge clk);
        addr = a; wdata = d; sel_a_n = s1n; sel_b = s2; sel_c_n = s3n;
        wr_all_n = wan; wr_byte_n = wbn; lane_n = ln; standby = slp;
        sel = !s1n && s2 && !s3n && !slp;
        it.tag    = tag;
        it.due    = cyc + (flow_thru ? 1 : 2);
        it.exp_on = 1'b0;
        it.exp_d  = '0;
        if (sel && !wan) begin
            model[a] = d;
        end else if (sel && !wbn) begin
            if (!ln[0]) model[a][8:0]  = d[8:0];
            if (!ln[1]) model[a][17:9] = d[17:9];
        end else if (sel) begin
            it.exp_on = 1'b1;
            it.exp_d  = model[a];
        end
        sbq.push_back(it);
    endtask

    task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        cmd(a, d, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, tag);
    endtask

    task automatic wr_lane(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [1:0] ln, input string tag);
        cmd(a, d, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ln, 1'b0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        cmd(a, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, tag);
    endtask

    task automatic idle(input string tag);
        cmd('0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, tag);
    endtask

    // Monitor: pops expectations as they fall due and compares the ports
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                item_t it;
                it = sbq.pop_front();
                if (it.due < cyc)
                    check(1'b0, {it.tag, " (missed slot)"}, '0, '0);
                else
                    check((rdata_drive === it.exp_on) &&
                          (!it.exp_on || rdata === it.exp_d),
                          it.tag, {rdata_drive, rdata}, {it.exp_on, it.exp_d});
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        // R10: quiet under reset and just after it
        #1;
        check(rdata_drive === 1'b0, "R10 in reset", {18'h0, rdata_drive}, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check(rdata_drive === 1'b0, "R10 after reset", {18'h0, rdata_drive}, '0);

        // Flow-through mode
        wr_all(6'd1, 18'h2A5A5, "R1 write");
        rd(6'd1, "R1 R5 readback");
        cmd(6'd5, 18'h1C3C3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, "R1 strobes ignored");
        rd(6'd5, "R1 readback");
        wr_all(6'd2, 18'h1FF00, "R2 base");
        wr_lane(6'd2, 18'h000AB, 2'b10, "R2 lane0");
        rd(6'd2, "R2 lane0 readback");
        wr_lane(6'd2, 18'h3FE00, 2'b01, "R2 lane1");
        rd(6'd2, "R2 lane1 readback");
        wr_lane(6'd2, 18'h15555, 2'b11, "R2 no lanes");
        rd(6'd2, "R2 unchanged");
        cmd(6'd3, 18'h24681, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R3 priority write");
        rd(6'd3, "R3 readback");

        // R4: each select wrong in turn
        cmd(6'd1, 18'h0DEAD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, "R4 sel_a off");
        cmd(6'd1, 18'h0BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, "R4 sel_b off");
        cmd(6'd1, 18'h0CAFE, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, "R4 sel_c off");
        cmd(6'd1, 18'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, "R4 deselected read");
        rd(6'd1, "R4 contents kept");
        idle("R7 flow deselect off");

        // R8: output enable acts between edges
        rd(6'd1, "R8 read");
        @(posedge clk);
        #1.5 out_en_n = 1'b1;
        #0.2 check(rdata_drive === 1'b0, "R8 disabled", {18'h0, rdata_drive}, '0);
        out_en_n = 1'b0;
        #0.2 check(rdata_drive === 1'b1, "R8 re-enabled", {18'h0, rdata_drive}, 19'h1);

        // R9: standby acts between edges and blocks accesses
        rd(6'd3, "R9 read");
        @(posedge clk);
        #1.5 standby = 1'b1;
        #0.2 check(rdata_drive === 1'b0, "R9 standby off", {18'h0, rdata_drive}, '0);
        standby = 1'b0;
        #0.2 check(rdata_drive === 1'b1, "R9 standby released", {18'h0, rdata_drive}, 19'h1);
        cmd(6'd3, 18'h00BAD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, "R9 write in standby");
        cmd(6'd3, 18'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, "R9 read in standby");
        rd(6'd3, "R9 resume and contents kept");
        idle("R7 flow idle");
        idle("R7 flow idle");

        // Pipelined mode
        flow_thru = 1'b0;
        idle("R7 pipe idle");
        rd(6'd1, "R6 pipe read a1");
        rd(6'd2, "R6 pipe read a2");
        rd(6'd3, "R6 pipe read a3");
        idle("R7 pipe extra cycle");
        idle("R7 pipe off");
        wr_all(6'd4, 18'h12345, "R7 pipe write off");
        rd(6'd4, "R6 pipe readback");
        wr_all(6'd4, 18'h2FEDC, "R6 write after read");
        rd(6'd4, "R6 new data");
        wr_lane(6'd4, 18'h001FF, 2'b10, "R2 pipe lane0");
        rd(6'd4, "R2 pipe readback");
        idle("R7 pipe idle");
        idle("R7 pipe idle");
        repeat (4) @(posedge clk);
        #2;
        check(sbq.size() == 0, "scoreboard drained", sbq.size(), '0);
        finish_run();
    end

endmodule